// File: doc/BRIEF.md
# Decode Slot Steering with Compare-Branch Fusion

This block sits between an instruction queue and a bank of four decoders. Each cycle it looks at a window of up to five entries at the head of the queue. Each entry carries an opaque payload and a few attributes that were found earlier in the pipe: a valid bit, a micro-op count, a flag that marks a compare or test, and a flag that marks a conditional branch.

The block hands these entries, oldest first, to four decode slots. Slot 0 feeds the one decoder that can expand an instruction into several micro-ops. Slots 1 to 3 feed decoders that only handle single-micro-op instructions. A compare that is followed at once by a conditional branch is merged into one slot. That slot carries both payloads and raises a fused flag, so one cycle can drain five queue entries. An instruction too long for the complex decoder is marked for the microcode path and goes through slot 0 with nothing beside it.

The number of entries taken is produced combinationally in the same cycle, so the queue can pop them. The slot contents appear one cycle later, from the decode-stage register.

Top module: `decode_steer`

## Requirements
- R1: `take_cnt` equals the number of window entries placed in slots this cycle (0 to 5), counting a fused pair as two. It is 0 whenever entry 0 is not valid.
- R2: Entries are placed strictly oldest first, entry i at bits i of each window vector. Slot k+1 is used only if slot k is. The first entry that is invalid or cannot be placed stops the group, and every younger entry waits.
- R3: An entry with a micro-op count of 1 may go to any slot. Four valid single-micro-op entries without fusion fill slots 0 to 3, and `take_cnt` is 4.
- R4: An entry with a micro-op count of 2 to 4 is placed only in slot 0. If it is the next entry when slot 0 is already taken, the group ends before it.
- R5: A valid compare (`q_cmp`) directly followed by a valid conditional branch (`q_jcc`) is fused when both have a micro-op count of 1. The pair uses one slot, with `slot_fused` set, the compare payload on `slot_data` and the branch payload on `slot_br_data`. The pair counts as two entries taken.
- R6: At most one pair is fused per cycle. A later compare-branch pair in the same window goes to two separate slots.
- R7: A compare in the last window position, or one whose next entry is invalid or not a branch, is decoded alone and is not fused.
- R8: An entry with a micro-op count above 4 that reaches slot 0 is placed there alone, with `slot_ucode` set, and `take_cnt` is 1. If it is the next entry when slot 0 is already taken, it waits.
- R9: Slot outputs change only at the clock edge after the window they come from. A synchronous active-low reset clears `slot_vld`, `slot_fused` and `slot_ucode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_vld | input | 5 | Valid bit per window entry, entry 0 oldest |
| q_cmp | input | 5 | Entry is a compare/test |
| q_jcc | input | 5 | Entry is a conditional branch |
| q_uops | input | 15 | Micro-op count per entry, 3 bits each, entry i at [3i+2:3i] |
| q_data | input | 80 | Payload per entry, 16 bits each |
| take_cnt | output | 3 | Entries to pop from the queue this cycle |
| slot_vld | output | 4 | Slot holds an instruction |
| slot_fused | output | 4 | Slot holds a fused compare-branch pair |
| slot_ucode | output | 4 | Slot holds an instruction for the microcode path |
| slot_data | output | 64 | Payload per slot (compare payload for a fused slot) |
| slot_br_data | output | 64 | Branch payload per slot, meaningful when fused |

## Verification
The hardest cases come when fusion and the decoder asymmetry act in the same cycle. One such case is a fused pair in slot 0 followed by a multi-micro-op instruction that must stall. Another is a fused pair forming across the last two window positions at slot 3. A third is a second compare-branch pair in a window whose single fusion has already been used. Directed windows build each of these cases. For each one the bench works out by hand the expected pop count, slot mask, fused mask and per-slot payloads. It checks the pop count before the clock edge and the slot contents after it.

// File: rtl/dsteer_pkg.sv
// Package: shared widths and types for decode slot steering.
// Assumes micro-op counts fit in UOP_W bits; a count of 0 or 1 is single-uop.
package dsteer_pkg;
    localparam int UOP_W      = 3;
    localparam int SINGLE_MAX = 1;
    typedef logic [UOP_W-1:0] uop_cnt_t;
endpackage

// File: rtl/decode_slot_stage.sv
// decode_slot_stage: decides what one decode slot receives.
// Takes the window position reached by the older slots and the fusion-used
// flag. It returns the grant, the fuse and microcode flags, the payloads and
// the position for the next slot. Assumes pos_in may point past the window,
// in which case nothing is granted.
module decode_slot_stage
    import dsteer_pkg::*;
#(
    parameter int WIN        = 5,
    parameter int DW         = 16,
    parameter int CPLX_MAX   = 4,
    parameter bit IS_COMPLEX = 1'b0,
    parameter int PW         = 3
) (
    input  logic [WIN-1:0]       win_vld,
    input  logic [WIN-1:0]       win_cmp,
    input  logic [WIN-1:0]       win_jcc,
    input  logic [WIN*UOP_W-1:0] win_uops,
    input  logic [WIN*DW-1:0]    win_data,
    input  logic [PW-1:0]        pos_in,
    input  logic                 live_in,
    input  logic                 pair_used_in,
    output logic [PW-1:0]        pos_out,
    output logic                 live_out,
    output logic                 pair_used_out,
    output logic                 grant,
    output logic                 fuse,
    output logic                 ucode,
    output logic [DW-1:0]        data,
    output logic [DW-1:0]        br_data
);
    logic          cur_v, cur_c, nxt_v, nxt_j;
    uop_cnt_t      cur_u, nxt_u;
    logic [DW-1:0] cur_d, nxt_d;
    logic          cur_single, cur_long;
    logic [PW-1:0] pos_nxt;

    assign pos_nxt = pos_in + PW'(1);

    // Fetch the attributes of the entry at pos_in and of the one after it.
    always_comb begin
        cur_v = 1'b0; cur_c = 1'b0; cur_u = '0; cur_d = '0;
        nxt_v = 1'b0; nxt_j = 1'b0; nxt_u = '0; nxt_d = '0;
        for (int i = 0; i < WIN; i++) begin
            if (PW'(i) == pos_in) begin
                cur_v = win_vld[i];
                cur_c = win_cmp[i];
                cur_u = win_uops[i*UOP_W +: UOP_W];
                cur_d = win_data[i*DW +: DW];
            end
            if (PW'(i) == pos_nxt) begin
                nxt_v = win_vld[i];
                nxt_j = win_jcc[i];
                nxt_u = win_uops[i*UOP_W +: UOP_W];
                nxt_d = win_data[i*DW +: DW];
            end
        end
    end

    // Classify the candidate and decide grant, fusion and how far to advance.
    always_comb begin
        cur_single    = (cur_u <= uop_cnt_t'(SINGLE_MAX));
        cur_long      = (cur_u > uop_cnt_t'(CPLX_MAX));
        grant         = live_in && cur_v && (IS_COMPLEX || cur_single);
        fuse          = grant && cur_single && cur_c && !pair_used_in &&
                        nxt_v && nxt_j && (nxt_u <= uop_cnt_t'(SINGLE_MAX));
        ucode         = grant && cur_long;
        live_out      = grant && !cur_long;
        pair_used_out = pair_used_in || fuse;
        pos_out       = pos_in + (grant ? (fuse ? PW'(2) : PW'(1)) : PW'(0));
        data          = cur_d;
        br_data       = fuse ? nxt_d : '0;
    end
endmodule

// File: rtl/decode_slot_reg.sv
// decode_slot_reg: decode-stage register holding the steered slot contents.
// Synchronous active-low reset clears every flag and payload.
module decode_slot_reg #(
    parameter int SLOTS = 4,
    parameter int DW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SLOTS-1:0]    d_vld,
    input  logic [SLOTS-1:0]    d_fused,
    input  logic [SLOTS-1:0]    d_ucode,
    input  logic [SLOTS*DW-1:0] d_data,
    input  logic [SLOTS*DW-1:0] d_br,
    output logic [SLOTS-1:0]    q_vld,
    output logic [SLOTS-1:0]    q_fused,
    output logic [SLOTS-1:0]    q_ucode,
    output logic [SLOTS*DW-1:0] q_data,
    output logic [SLOTS*DW-1:0] q_br
);
    // Capture the steering result once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld   <= '0;
            q_fused <= '0;
            q_ucode <= '0;
            q_data  <= '0;
            q_br    <= '0;
        end else begin
            q_vld   <= d_vld;
            q_fused <= d_fused;
            q_ucode <= d_ucode;
            q_data  <= d_data;
            q_br    <= d_br;
        end
    end
endmodule

// File: rtl/decode_steer.sv
// decode_steer: steers up to WIN queue-head entries onto SLOTS decode slots.
// Slot 0 is the complex decoder and the rest are single-uop decoders. At most
// one compare+branch pair is fused per cycle. take_cnt is combinational for
// the queue pop, and slot outputs are registered. Assumes the window is packed
// with entry 0 as the oldest.
module decode_steer
    import dsteer_pkg::*;
#(
    parameter int WIN      = 5,
    parameter int SLOTS    = 4,
    parameter int DW       = 16,
    parameter int CPLX_MAX = 4,
    localparam int PW      = $clog2(WIN + 2),
    localparam int CW      = $clog2(WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN-1:0]       q_vld,
    input  logic [WIN-1:0]       q_cmp,
    input  logic [WIN-1:0]       q_jcc,
    input  logic [WIN*UOP_W-1:0] q_uops,
    input  logic [WIN*DW-1:0]    q_data,
    output logic [CW-1:0]        take_cnt,
    output logic [SLOTS-1:0]     slot_vld,
    output logic [SLOTS-1:0]     slot_fused,
    output logic [SLOTS-1:0]     slot_ucode,
    output logic [SLOTS*DW-1:0]  slot_data,
    output logic [SLOTS*DW-1:0]  slot_br_data
);
    logic [PW-1:0]       pos_chain  [SLOTS+1];
    logic                live_chain [SLOTS+1];
    logic                pair_chain [SLOTS+1];
    logic [SLOTS-1:0]    st_vld, st_fused, st_ucode;
    logic [SLOTS*DW-1:0] st_data, st_br;

    assign pos_chain[0]  = '0;
    assign live_chain[0] = 1'b1;
    assign pair_chain[0] = 1'b0;

    // One stage per slot, chained in program order; only slot 0 is complex.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        decode_slot_stage #(
            .WIN(WIN), .DW(DW), .CPLX_MAX(CPLX_MAX),
            .IS_COMPLEX(s == 0), .PW(PW)
        ) u_stage (
            .win_vld      (q_vld),
            .win_cmp      (q_cmp),
            .win_jcc      (q_jcc),
            .win_uops     (q_uops),
            .win_data     (q_data),
            .pos_in       (pos_chain[s]),
            .live_in      (live_chain[s]),
            .pair_used_in (pair_chain[s]),
            .pos_out      (pos_chain[s+1]),
            .live_out     (live_chain[s+1]),
            .pair_used_out(pair_chain[s+1]),
            .grant        (st_vld[s]),
            .fuse         (st_fused[s]),
            .ucode        (st_ucode[s]),
            .data         (st_data[s*DW +: DW]),
            .br_data      (st_br[s*DW +: DW])
        );
    end

    assign take_cnt = CW'(pos_chain[SLOTS]);

    decode_slot_reg #(.SLOTS(SLOTS), .DW(DW)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_vld  (st_vld),
        .d_fused(st_fused),
        .d_ucode(st_ucode),
        .d_data (st_data),
        .d_br   (st_br),
        .q_vld  (slot_vld),
        .q_fused(slot_fused),
        .q_ucode(slot_ucode),
        .q_data (slot_data),
        .q_br   (slot_br_data)
    );

    // Marks cycles whose previous edge was already out of reset.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: an invalid queue head pops nothing.
    a_r1_idle_head: assert property (@(posedge clk) disable iff (!rst_n)
        !q_vld[0] |-> take_cnt == '0);

    // R1: registered slots account for exactly the entries popped last cycle.
    a_r1_pop_matches: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (int'($countones(slot_vld)) + int'($countones(slot_fused)))
                    == int'($past(take_cnt)));

    // R2: occupied slots form a prefix starting at slot 0.
    for (genvar s = 1; s < SLOTS; s++) begin : g_prefix
        a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[s] |-> slot_vld[s-1]);
    end

    // R5: a fused flag only appears on an occupied slot.
    a_r5_fuse_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_fused & ~slot_vld) == '0);

    // R6: no more than one fused pair per group.
    a_r6_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_fused));

    // R8: a microcode entry sits in slot 0 with every other slot empty.
    a_r8_ucode_alone: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ucode != '0 |-> (slot_ucode == SLOTS'(1) && slot_vld == SLOTS'(1)));
endmodule

// File: tb/tb_decode_steer.sv
module tb_decode_steer;
    localparam int WIN = 5, SLOTS = 4, DW = 16, UW = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [WIN-1:0]      q_vld = '0, q_cmp = '0, q_jcc = '0;
    logic [WIN*UW-1:0]   q_uops = '0;
    logic [WIN*DW-1:0]   q_data = '0;
    logic [2:0]          take_cnt;
    logic [SLOTS-1:0]    slot_vld, slot_fused, slot_ucode;
    logic [SLOTS*DW-1:0] slot_data, slot_br_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] salt = 8'h10;

    decode_steer dut (
        .clk(clk), .rst_n(rst_n),
        .q_vld(q_vld), .q_cmp(q_cmp), .q_jcc(q_jcc),
        .q_uops(q_uops), .q_data(q_data),
        .take_cnt(take_cnt),
        .slot_vld(slot_vld), .slot_fused(slot_fused), .slot_ucode(slot_ucode),
        .slot_data(slot_data), .slot_br_data(slot_br_data)
    );

    always #10 clk = ~clk;

    function automatic logic [14:0] pk(input int u4, u3, u2, u1, u0);
        return {3'(u4), 3'(u3), 3'(u2), 3'(u1), 3'(u0)};
    endfunction

    function automatic logic [DW-1:0] pay(input int idx);
        return {salt, 8'(idx)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply a window at the falling edge with a fresh payload salt.
    task automatic load(input logic [4:0] v, c, j, input logic [14:0] u);
        @(negedge clk);
        salt = salt + 8'h11;
        q_vld = v; q_cmp = c; q_jcc = j; q_uops = u;
        for (int i = 0; i < WIN; i++) q_data[i*DW +: DW] = pay(i);
        #2;
    endtask

    task automatic exp_take(input int e, input string req);
        chk(int'(take_cnt) == e, req, "take_cnt", int'(take_cnt), e);
    endtask

    // ix/bx hold expected entry index per slot, 4 bits each, slot 0 lowest.
    task automatic exp_slots(input logic [3:0] ev, ef, eu,
                             input logic [15:0] ix, bx, input string req);
        @(posedge clk); #2;
        chk(slot_vld == ev, req, "slot_vld", int'(slot_vld), int'(ev));
        chk(slot_fused == ef, req, "slot_fused", int'(slot_fused), int'(ef));
        chk(slot_ucode == eu, req, "slot_ucode", int'(slot_ucode), int'(eu));
        for (int s = 0; s < SLOTS; s++) begin
            if (ev[s])
                chk(slot_data[s*DW +: DW] == pay(int'(ix[s*4 +: 4])), req, "slot_data",
                    int'(slot_data[s*DW +: DW]), int'(pay(int'(ix[s*4 +: 4]))));
            if (ef[s])
                chk(slot_br_data[s*DW +: DW] == pay(int'(bx[s*4 +: 4])), req, "slot_br_data",
                    int'(slot_br_data[s*DW +: DW]), int'(pay(int'(bx[s*4 +: 4]))));
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        load(5'b11111, 5'b00001, 5'b00010, pk(1,1,1,1,1));
        @(posedge clk); #2;
        chk(slot_vld == 4'b0, "R9", "reset slot_vld", int'(slot_vld), 0);
        chk(slot_fused == 4'b0, "R9", "reset slot_fused", int'(slot_fused), 0);
        chk(slot_ucode == 4'b0, "R9", "reset slot_ucode", int'(slot_ucode), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_head_idle;
        load(5'b11110, 5'b0, 5'b0, pk(1,1,1,1,1));
        exp_take(0, "R1");
        exp_slots(4'b0000, 4'b0, 4'b0, 16'h0, 16'h0, "R1");
    endtask

    task automatic t_four_singles;
        load(5'b11111, 5'b0, 5'b0, pk(1,1,1,1,1));
        exp_take(4, "R3");
        exp_slots(4'b1111, 4'b0, 4'b0, 16'h3210, 16'h0, "R3");
    endtask

    task automatic t_cmp_no_branch;
        load(5'b11111, 5'b00001, 5'b00100, pk(1,1,1,1,1));
        exp_take(4, "R7");
        exp_slots(4'b1111, 4'b0, 4'b0, 16'h3210, 16'h0, "R7");
    endtask

    task automatic t_fuse_head;
        load(5'b11111, 5'b00001, 5'b00010, pk(1,1,1,1,1));
        exp_take(5, "R5");
        exp_slots(4'b1111, 4'b0001, 4'b0, 16'h4320, 16'h0001, "R5");
    endtask

    task automatic t_fuse_tail;
        load(5'b11111, 5'b01000, 5'b10000, pk(1,1,1,1,1));
        exp_take(5, "R5");
        exp_slots(4'b1111, 4'b1000, 4'b0, 16'h3210, 16'h4000, "R5");
    endtask

    task automatic t_two_pairs;
        load(5'b11111, 5'b00101, 5'b01010, pk(1,1,1,1,1));
        exp_take(5, "R6");
        exp_slots(4'b1111, 4'b0001, 4'b0, 16'h4320, 16'h0001, "R6");
    endtask

    task automatic t_cmp_last;
        load(5'b11111, 5'b10001, 5'b00010, pk(1,1,1,1,1));
        exp_take(5, "R7");
        exp_slots(4'b1111, 4'b0001, 4'b0, 16'h4320, 16'h0001, "R7");
        load(5'b01111, 5'b01000, 5'b10000, pk(1,1,1,1,1));
        exp_take(4, "R7");
        exp_slots(4'b1111, 4'b0000, 4'b0, 16'h3210, 16'h0, "R7");
    endtask

    task automatic t_multi;
        load(5'b11111, 5'b0, 5'b0, pk(1,1,1,1,3));
        exp_take(4, "R4");
        exp_slots(4'b1111, 4'b0, 4'b0, 16'h3210, 16'h0, "R4");
        load(5'b11111, 5'b0, 5'b0, pk(1,1,3,1,1));
        exp_take(2, "R4");
        exp_slots(4'b0011, 4'b0, 4'b0, 16'h0010, 16'h0, "R4");
        load(5'b11111, 5'b00001, 5'b00010, pk(1,1,2,1,1));
        exp_take(2, "R4");
        exp_slots(4'b0001, 4'b0001, 4'b0, 16'h0000, 16'h0001, "R4");
    endtask

    task automatic t_ucode;
        load(5'b11111, 5'b0, 5'b0, pk(1,1,1,1,6));
        exp_take(1, "R8");
        exp_slots(4'b0001, 4'b0, 4'b0001, 16'h0000, 16'h0, "R8");
        load(5'b11111, 5'b0, 5'b0, pk(1,1,1,7,1));
        exp_take(1, "R8");
        exp_slots(4'b0001, 4'b0, 4'b0000, 16'h0000, 16'h0, "R8");
    endtask

    task automatic t_gap;
        load(5'b11011, 5'b0, 5'b0, pk(1,1,1,1,1));
        exp_take(2, "R2");
        exp_slots(4'b0011, 4'b0, 4'b0, 16'h0010, 16'h0, "R2");
    endtask

    task automatic t_register_timing;
        load(5'b11111, 5'b0, 5'b0, pk(1,1,1,1,1));
        exp_slots(4'b1111, 4'b0, 4'b0, 16'h3210, 16'h0, "R9");
        load(5'b00000, 5'b0, 5'b0, pk(1,1,1,1,1));
        chk(slot_vld == 4'b1111, "R9", "slot_vld before edge", int'(slot_vld), 15);
        exp_slots(4'b0000, 4'b0, 4'b0, 16'h0, 16'h0, "R9");
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_head_idle();
        t_four_singles();
        t_cmp_no_branch();
        t_fuse_head();
        t_fuse_tail();
        t_two_pairs();
        t_cmp_last();
        t_multi();
        t_ucode();
        t_gap();
        t_register_timing();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule